// File: doc/BRIEF.md
# Reload Timer with Interrupt Flag

An 8-bit up-counting timer for a small microcontroller peripheral bus. An 11-bit prescaler runs off the system clock. A 3-bit clock-select field picks one of its taps, or the undivided clock, and that source advances the counter. When the counter passes 0xFF it either wraps to 0x00 (free-running) or restarts from a software preset (reload). In both cases it raises a sticky overflow flag.

Software configures the block through a narrow write port of 4-bit registers. The preset is written one nibble at a time. Each nibble write also copies the assembled preset straight into the counter. The flag stays set until software writes 0 to it. A mask bit, which comes out of reset set, gates the request to the CPU together with a global interrupt enable. A stop input returns the timer state to its reset values and freezes the prescaler. A watch input only freezes the prescaler.

Register addresses: 0 = mode (bit 3 = reload enable, bits 2:0 = clock select), 1 = preset low nibble, 2 = preset high nibble, 3 = flag (bit 0), 4 = mask (bit 0).

Top module: `rld_timer`

## Requirements
- R1: After reset, the counter is 0x00, the flag reads 0, the mask reads 1, the mode is 0 and irq_o is 0.
- R2: With clock select 7, the counter increases by one on every clock edge while neither stop nor watch is active.
- R3: Clock selects 0 to 6 advance the counter once per 2, 4, 8, 32, 128, 512 and 2048 cycles respectively. The tick is made on the rising transition of the selected prescaler tap.
- R4: A write to address 1 or 2 stores that nibble of the preset and loads the counter with the assembled preset in the same edge.
- R5: In free-running mode (mode bit 3 = 0), a tick at 0xFF wraps the counter to 0x00 and sets the flag.
- R6: In reload mode (mode bit 3 = 1), a tick at 0xFF loads the counter with the preset and sets the flag.
- R7: The flag stays set until a write of 0 to bit 0 at address 3 clears it. Writing 1 there has no effect.
- R8: irq_o is 1 only when the flag is 1, the mask is 0 and gie_i is 1.
- R9: While stop_i is high, the mode and counter clear to 0, the flag clears to 0 and the mask sets to 1. The prescaler holds.
- R10: While watch_i is high, the prescaler holds, so the counter does not advance. Counting resumes when watch_i falls.
- R11: When a preset nibble write and an overflow occur in the same cycle, the counter takes the written preset and the flag is still set.
- R12: rd_data returns the flag at address 3 and the mask at address 4, both in bit 0. Every other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_i | input | 1 | Stop mode: clears timer state, halts prescaler |
| watch_i | input | 1 | Watch mode: halts prescaler |
| gie_i | input | 1 | Global interrupt enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 4 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 4 | Register read data (combinational) |
| cnt_o | output | 8 | Current counter value |
| irq_o | output | 1 | Interrupt request to the CPU |

## Verification
Every register in the block updates on the edge that samples the write, stop or tick. A preset write or an overflow is therefore visible on cnt_o and rd_data one edge later, and irq_o and rd_data follow combinationally from that state. The bench drives on the falling edge and reads on the next falling edge, after counting each rising edge that has passed. The divide ratios cannot be checked at a fixed phase, so the bench waits a whole number of tap periods and compares the count difference, which does not depend on the prescaler phase.

// File: rtl/rld_timer.sv
module rld_timer #(
  parameter int PRE_W = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stop_i,
  input  logic       watch_i,
  input  logic       gie_i,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [3:0] wr_data,
  input  logic [2:0] rd_addr,
  output logic [3:0] rd_data,
  output logic [7:0] cnt_o,
  output logic       irq_o
);
  localparam logic [2:0] A_MODE = 3'd0;
  localparam logic [2:0] A_PLO  = 3'd1;
  localparam logic [2:0] A_PHI  = 3'd2;
  localparam logic [2:0] A_FLAG = 3'd3;
  localparam logic [2:0] A_MASK = 3'd4;
  localparam logic [2:0] SEL_FAST = 3'd7;

  logic [3:0]       mode_q, plo_q, phi_q;
  logic [7:0]       cnt_q;
  logic [PRE_W-1:0] pre_q;
  logic             flag_q, mask_q, tap_q, tap;

  wire run     = ~stop_i & ~watch_i;
  wire wr_mode = wr_en && wr_addr == A_MODE;
  wire wr_lo   = wr_en && wr_addr == A_PLO;
  wire wr_hi   = wr_en && wr_addr == A_PHI;
  wire wr_flag = wr_en && wr_addr == A_FLAG;
  wire wr_mask = wr_en && wr_addr == A_MASK;

  always_comb begin
    case (mode_q[2:0])
      3'd0:    tap = pre_q[0];
      3'd1:    tap = pre_q[1];
      3'd2:    tap = pre_q[2];
      3'd3:    tap = pre_q[4];
      3'd4:    tap = pre_q[6];
      3'd5:    tap = pre_q[8];
      3'd6:    tap = pre_q[10];
      default: tap = 1'b0;
    endcase
  end

  wire tick = (mode_q[2:0] == SEL_FAST) ? run : (tap & ~tap_q);
  wire ovf  = tick && cnt_q == 8'hFF;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      tap_q  <= 1'b0;
      mode_q <= 4'h0;
      plo_q  <= 4'h0;
      phi_q  <= 4'h0;
      cnt_q  <= 8'h00;
      flag_q <= 1'b0;
      mask_q <= 1'b1;
    end else begin
      if (run) pre_q <= pre_q + 1'b1;
      tap_q <= tap;
      if (stop_i) begin
        mode_q <= 4'h0;
        cnt_q  <= 8'h00;
        flag_q <= 1'b0;
        mask_q <= 1'b1;
      end else begin
        if (wr_mode) mode_q <= wr_data;
        if (wr_lo)   plo_q  <= wr_data;
        if (wr_hi)   phi_q  <= wr_data;
        if (wr_lo)       cnt_q <= {phi_q, wr_data};
        else if (wr_hi)  cnt_q <= {wr_data, plo_q};
        else if (ovf)    cnt_q <= mode_q[3] ? {phi_q, plo_q} : 8'h00;
        else if (tick)   cnt_q <= cnt_q + 8'd1;
        if (ovf)                          flag_q <= 1'b1;
        else if (wr_flag && !wr_data[0])  flag_q <= 1'b0;
        if (wr_mask) mask_q <= wr_data[0];
      end
    end
  end

  assign cnt_o   = cnt_q;
  assign irq_o   = flag_q & ~mask_q & gie_i;
  assign rd_data = (rd_addr == A_FLAG) ? {3'b000, flag_q} :
                   (rd_addr == A_MASK) ? {3'b000, mask_q} : 4'h0;

  AST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_i && tick && cnt_q != 8'hFF && !wr_lo && !wr_hi) |=> cnt_q == $past(cnt_q) + 8'd1); // R2
  AST_PRESET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_i && wr_hi) |=> cnt_q[7:4] == $past(wr_data)); // R4
  AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_i && ovf && !mode_q[3] && !wr_lo && !wr_hi) |=> (cnt_q == 8'h00 && flag_q)); // R5
  AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_i && ovf && mode_q[3] && !wr_lo && !wr_hi) |=> (cnt_q == $past({phi_q, plo_q}) && flag_q)); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !stop_i && !(wr_flag && !wr_data[0])) |=> flag_q); // R7
  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q |-> !irq_o); // R8
  AST_STOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> (cnt_q == 8'h00 && !flag_q && mask_q && mode_q == 4'h0)); // R9
  AST_WATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    watch_i |=> pre_q == $past(pre_q)); // R10
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_i && wr_lo && ovf) |=> (cnt_q[3:0] == $past(wr_data) && flag_q)); // R11
endmodule

// File: tb/rld_timer_tb.sv
module rld_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stop_i = 1'b0, watch_i = 1'b0, gie_i = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = 3'd0, rd_addr = 3'd0;
  logic [3:0] wr_data = 4'h0, rd_data;
  logic [7:0] cnt_o;
  logic       irq_o;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rld_timer u_dut (
    .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .watch_i(watch_i), .gie_i(gie_i),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cnt_o(cnt_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [3:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] a, output logic [3:0] v);
    rd_addr = a; #1 v = rd_data;
  endtask

  task automatic preset(input logic [7:0] p);
    wr(3'd1, p[3:0]); wr(3'd2, p[7:4]);
  endtask

  task automatic t_reset;
    logic [3:0] v;
    chk("R1 cnt", cnt_o, 8'h00);
    rd(3'd3, v); chk("R1 flag", v, 0);
    rd(3'd4, v); chk("R1 mask", v, 1);
    rd(3'd0, v); chk("R1 mode reads 0", v, 0);
    gie_i = 1'b1; #1 chk("R1 irq", irq_o, 0);
  endtask

  task automatic t_step;
    wr(3'd0, 4'h7); preset(8'h3C);
    chk("R4 preset load", cnt_o, 8'h3C);
    cyc(5); chk("R2 step", cnt_o, 8'h41);
  endtask

  task automatic t_div;
    int ratio [7] = '{2, 4, 8, 32, 128, 512, 2048};
    for (int s = 0; s < 7; s++) begin
      int k;
      k = (ratio[s] <= 256) ? 256 / ratio[s] : 1;
      if (k > 128) k = 128;
      wr(3'd0, 4'(s)); preset(8'h00);
      cyc(k * ratio[s]);
      chk($sformatf("R3 sel %0d", s), cnt_o, k);
    end
  endtask

  task automatic t_wrap;
    logic [3:0] v;
    wr(3'd3, 4'h0); wr(3'd0, 4'h7); preset(8'hFE);
    cyc(1); chk("R5 at FF", cnt_o, 8'hFF);
    rd(3'd3, v); chk("R5 flag before", v, 0);
    cyc(1); chk("R5 wrap", cnt_o, 8'h00);
    rd(3'd3, v); chk("R5 flag set", v, 1);
  endtask

  task automatic t_flag;
    logic [3:0] v;
    wr(3'd3, 4'h1); rd(3'd3, v); chk("R7 write 1 ignored", v, 1);
    wr(3'd3, 4'hE); rd(3'd3, v); chk("R7 write 0 clears", v, 0);
  endtask

  task automatic t_reload;
    logic [3:0] v;
    wr(3'd0, 4'hF); preset(8'hFD);
    cyc(2); chk("R6 at FF", cnt_o, 8'hFF);
    cyc(1); chk("R6 reload", cnt_o, 8'hFD);
    rd(3'd3, v); chk("R6 flag", v, 1);
  endtask

  task automatic t_irq;
    wr(3'd0, 4'h0);
    gie_i = 1'b1; #1 chk("R8 mask set holds", irq_o, 0);
    wr(3'd4, 4'h0); chk("R8 request", irq_o, 1);
    gie_i = 1'b0; #1 chk("R8 gie off", irq_o, 0);
    gie_i = 1'b1; wr(3'd4, 4'h1); chk("R8 masked", irq_o, 0);
  endtask

  task automatic t_stop;
    logic [3:0] v;
    wr(3'd0, 4'h7); preset(8'hFF); cyc(1);
    wr(3'd4, 4'h0);
    stop_i = 1'b1; cyc(1); stop_i = 1'b0;
    chk("R9 cnt", cnt_o, 0);
    rd(3'd3, v); chk("R9 flag", v, 0);
    rd(3'd4, v); chk("R9 mask", v, 1);
    preset(8'h20); cyc(8);
    chk("R9 mode cleared", cnt_o, 8'h24);
  endtask

  task automatic t_watch;
    wr(3'd0, 4'h7); preset(8'h10);
    watch_i = 1'b1; cyc(5);
    chk("R10 hold", cnt_o, 8'h10);
    watch_i = 1'b0; cyc(3);
    chk("R10 resume", cnt_o, 8'h13);
  endtask

  task automatic t_race;
    logic [3:0] v;
    wr(3'd3, 4'h0); wr(3'd0, 4'hF); preset(8'hFE);
    cyc(1); chk("R11 at FF", cnt_o, 8'hFF);
    wr(3'd1, 4'h3);
    chk("R11 write wins", cnt_o, 8'hF3);
    rd(3'd3, v); chk("R11 flag set", v, 1);
  endtask

  task automatic t_read;
    logic [3:0] v;
    wr(3'd0, 4'h5); rd(3'd0, v); chk("R12 mode", v, 0);
    rd(3'd1, v); chk("R12 plo", v, 0);
    rd(3'd2, v); chk("R12 phi", v, 0);
    for (int a = 5; a < 8; a++) begin
      rd(3'(a), v); chk("R12 unused", v, 0);
    end
  endtask

  initial begin
    cyc(3); rst_n = 1'b1; cyc(1);
    t_reset; t_step; t_div; t_wrap; t_flag; t_reload;
    t_irq; t_stop; t_watch; t_race; t_read;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule